// File: doc/BRIEF.md
# DDR Output Bit Interleaver

This block sits between a 14-bit sampling core and a source-synchronous output port. Once per sample period it takes a result word and an out-of-range flag. It then presents the word on seven lanes at double data rate, two adjacent bits per lane. A forwarded clock travels with the lanes and marks which half of the period carries which bit. A separate lane carries the overflow/underflow flag.

All logic runs on a single internal clock at four times the sample rate, so each sample period has four quarters. A small state machine steps through these quarters. It has an idle state used only after reset (`Q_IDLE`), two quarters for the even half (`Q_EVEN_A`, `Q_EVEN_B`) and two quarters for the odd half (`Q_ODD_A`, `Q_ODD_B`). The transitions are `Q_IDLE -> Q_EVEN_A` on the first edge after reset, then `Q_EVEN_A -> Q_EVEN_B -> Q_ODD_A -> Q_ODD_B -> Q_EVEN_A`, repeating. The word is captured on the edge that leaves `Q_IDLE` or `Q_ODD_B`, which is the period boundary. The edge that leaves `Q_EVEN_B` is the half boundary.

A 2-bit phase setting delays the forwarded clock by whole quarters of the period: 0, 90, 180 or 270 degrees. This lets the receiver centre its sampling point in the data eye.

Top module: `ddr_interleaver`

## Requirements
- R1: While the machine is in `Q_EVEN_A` or `Q_EVEN_B`, lane i drives bit 2i of the shown word.
- R2: While the machine is in `Q_ODD_A` or `Q_ODD_B`, lane i drives bit 2i+1 of the shown word.
- R3: `smp_word` and `smp_ovf` are captured only on a period boundary edge, and values present on other edges have no effect. A word captured on one boundary becomes the shown word at the next boundary, four `clk_4x` edges later.
- R4: During the even half, `lane_ovf` equals the flag captured with the shown word.
- R5: During the odd half, `lane_ovf` is 0.
- R6: With phase setting 0, `fwd_clk` is low in the even half and high in the odd half, and it changes on the same edges as the lanes.
- R7: With phase setting k, `fwd_clk` is the phase-0 waveform delayed by k quarters of the period (k x 90 degrees).
- R8: `phase_sel` is sampled only on period boundary edges. The sampled value governs `fwd_clk` from that boundary edge until the next one.
- R9: While `rst_n` is low, all lanes, `lane_ovf` and `fwd_clk` are low, and reset clears the captured words.
- R10: After reset is released, the first edge moves the machine from `Q_IDLE` to `Q_EVEN_A`, and that edge is a period boundary. The first period shows an all-zero word with a clear flag, and the word captured on that edge is shown in the second period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_4x | input | 1 | Internal clock, four times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_sel | input | 2 | Forwarded clock delay in quarters of the period |
| smp_word | input | 2*LANES | Conversion result, captured on a period boundary |
| smp_ovf | input | 1 | Over/underflow flag of the same sample |
| lane | output | LANES | DDR data lanes; lane i carries bits 2i and 2i+1 |
| lane_ovf | output | 1 | DDR overflow lane, meaningful in the even half only |
| fwd_clk | output | 1 | Forwarded clock with programmable delay |

## Verification
A quarter state out of step shows up at once as a bit swap: odd bits appear where even bits are expected, and `lane_ovf` is set in the odd half. Within one or two `clk_4x` edges `fwd_clk` also loses its fixed relation to the lanes. A corrupted capture register shows as a wrong lane value in the period after the fault, four edges later. A corrupted phase register shows on `fwd_clk` within one quarter and persists until the next boundary. The bench therefore compares every output on every edge against an arithmetic model. It sweeps all four phase settings and feeds decoy values on edges that are not boundaries.

// File: rtl/ddr_il_pkg.sv
`timescale 1ns/1ps
package ddr_il_pkg;

    // Quarter of the output period currently shown on the lanes.
    typedef enum logic [2:0] {
        Q_EVEN_A = 3'd0,
        Q_EVEN_B = 3'd1,
        Q_ODD_A  = 3'd2,
        Q_ODD_B  = 3'd3,
        Q_IDLE   = 3'd4
    } quarter_t;

    localparam int PH_W = 2;

    // Position of a quarter inside the period (0..3).
    function automatic logic [1:0] quarter_idx(quarter_t q);
        logic [2:0] raw;
        raw = q;
        return raw[1:0];
    endfunction

    // Clock level in quarter nq when delayed by ph quarters.
    function automatic logic fwd_level(logic [1:0] nq, logic [PH_W-1:0] ph);
        logic [1:0] d;
        d = nq - ph;
        return d[1];
    endfunction

endpackage

// File: rtl/ddr_il_seq.sv
`timescale 1ns/1ps
module ddr_il_seq
    import ddr_il_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    output quarter_t state_q,
    output quarter_t state_nx,
    output logic     period_start,
    output logic     half_flip
);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state selection
    always_comb begin
        unique case (state_q)
            Q_IDLE:   state_nx = Q_EVEN_A;
            Q_EVEN_A: state_nx = Q_EVEN_B;
            Q_EVEN_B: state_nx = Q_ODD_A;
            Q_ODD_A:  state_nx = Q_ODD_B;
            Q_ODD_B:  state_nx = Q_EVEN_A;
            default:  state_nx = Q_IDLE;
        endcase
    end

    // Strobes for the edge that leaves the current state
    always_comb begin
        period_start = 1'b0;
        half_flip    = 1'b0;
        unique case (state_q)
            Q_IDLE, Q_ODD_B:   period_start = 1'b1;
            Q_EVEN_B:          half_flip    = 1'b1;
            Q_EVEN_A, Q_ODD_A: ;
            default:           ;
        endcase
    end

endmodule

// File: rtl/ddr_il_capture.sv
`timescale 1ns/1ps
module ddr_il_capture #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word_in,
    input  logic         ovf_in,
    output logic [W-1:0] cap_word,
    output logic         cap_ovf,
    output logic [W-1:0] shown_word
);

    // Two-deep pipe: cap holds the newest sample, shown the one on the lanes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_word   <= '0;
            cap_ovf    <= 1'b0;
            shown_word <= '0;
        end else if (load) begin
            shown_word <= cap_word;
            cap_word   <= word_in;
            cap_ovf    <= ovf_in;
        end
    end

endmodule

// File: rtl/ddr_il_lanes.sv
`timescale 1ns/1ps
module ddr_il_lanes #(
    parameter int LANES = 7,
    localparam int W    = 2 * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_start,
    input  logic             half_flip,
    input  logic [W-1:0]     next_word,
    input  logic             next_ovf,
    input  logic [W-1:0]     shown_word,
    output logic [LANES-1:0] lane,
    output logic             lane_ovf
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (period_start) begin
                bit_q <= next_word[2*g];
            end else if (half_flip) begin
                bit_q <= shown_word[2*g+1];
            end
        end
        assign lane[g] = bit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_ovf <= 1'b0;
        end else if (period_start) begin
            lane_ovf <= next_ovf;
        end else if (half_flip) begin
            lane_ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/ddr_il_clkgen.sv
`timescale 1ns/1ps
module ddr_il_clkgen
    import ddr_il_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            period_start,
    input  quarter_t        state_nx,
    input  logic [PH_W-1:0] phase_sel,
    output logic            fwd_clk
);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_use;

    // A new setting applies from the boundary edge on which it is sampled.
    always_comb begin
        ph_use = period_start ? phase_sel : ph_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q    <= '0;
            fwd_clk <= 1'b0;
        end else begin
            ph_q    <= ph_use;
            fwd_clk <= fwd_level(quarter_idx(state_nx), ph_use);
        end
    end

endmodule

// File: rtl/ddr_interleaver.sv
`timescale 1ns/1ps
module ddr_interleaver
    import ddr_il_pkg::*;
#(
    parameter int LANES = 7
) (
    input  logic                 clk_4x,
    input  logic                 rst_n,
    input  logic [1:0]           phase_sel,
    input  logic [2*LANES-1:0]   smp_word,
    input  logic                 smp_ovf,
    output logic [LANES-1:0]     lane,
    output logic                 lane_ovf,
    output logic                 fwd_clk
);

    localparam int WORD_W = 2 * LANES;

    quarter_t          state_q;
    quarter_t          state_nx;
    logic              period_start;
    logic              half_flip;
    logic [WORD_W-1:0] cap_word;
    logic              cap_ovf;
    logic [WORD_W-1:0] shown_word;

    ddr_il_seq u_seq (
        .clk          (clk_4x),
        .rst_n        (rst_n),
        .state_q      (state_q),
        .state_nx     (state_nx),
        .period_start (period_start),
        .half_flip    (half_flip)
    );

    ddr_il_capture #(.W(WORD_W)) u_capture (
        .clk        (clk_4x),
        .rst_n      (rst_n),
        .load       (period_start),
        .word_in    (smp_word),
        .ovf_in     (smp_ovf),
        .cap_word   (cap_word),
        .cap_ovf    (cap_ovf),
        .shown_word (shown_word)
    );

    ddr_il_lanes #(.LANES(LANES)) u_lanes (
        .clk          (clk_4x),
        .rst_n        (rst_n),
        .period_start (period_start),
        .half_flip    (half_flip),
        .next_word    (cap_word),
        .next_ovf     (cap_ovf),
        .shown_word   (shown_word),
        .lane         (lane),
        .lane_ovf     (lane_ovf)
    );

    ddr_il_clkgen u_clkgen (
        .clk          (clk_4x),
        .rst_n        (rst_n),
        .period_start (period_start),
        .state_nx     (state_nx),
        .phase_sel    (phase_sel),
        .fwd_clk      (fwd_clk)
    );

endmodule

// File: rtl/ddr_interleaver_chk.sv
`timescale 1ns/1ps
module ddr_interleaver_chk
    import ddr_il_pkg::*;
#(
    parameter int LANES = 7
) (
    input logic             clk,
    input logic             rst_n,
    input quarter_t         state,
    input logic [LANES-1:0] lanes,
    input logic             lane_ovf,
    input logic             fwd_clk
);

    // R5
    ovf_odd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_ODD_A || state == Q_ODD_B) |-> !lane_ovf);

    // R1 R2
    lanes_half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_EVEN_B || state == Q_ODD_B) |-> $stable(lanes));

    // R10
    seq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_ODD_B) |=> (state == Q_EVEN_A));

    // R10
    seq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_IDLE) |=> (state == Q_EVEN_A));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (lanes == '0 && !lane_ovf && !fwd_clk));

endmodule

bind ddr_interleaver ddr_interleaver_chk #(.LANES(LANES)) u_chk (
    .clk      (clk_4x),
    .rst_n    (rst_n),
    .state    (state_q),
    .lanes    (lane),
    .lane_ovf (lane_ovf),
    .fwd_clk  (fwd_clk)
);

// File: tb/test_ddr_interleaver.sv
`timescale 1ns/1ps
module test_ddr_interleaver;

    localparam int LANES = 7;
    localparam int WW    = 2 * LANES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       phase_sel = 2'd0;
    logic [WW-1:0]    smp_word = '0;
    logic             smp_ovf = 1'b0;
    logic [LANES-1:0] lane;
    logic             lane_ovf;
    logic             fwd_clk;

    always #2 clk = ~clk;

    ddr_interleaver #(.LANES(LANES)) i_ddr_interleaver (
        .clk_4x    (clk),
        .rst_n     (rst_n),
        .phase_sel (phase_sel),
        .smp_word  (smp_word),
        .smp_ovf   (smp_ovf),
        .lane      (lane),
        .lane_ovf  (lane_ovf),
        .fwd_clk   (fwd_clk)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Arithmetic model state
    logic [WW-1:0] m_cap, m_shown;
    logic          m_cap_ovf, m_shown_ovf;
    logic [1:0]    m_ph;
    int            m_edge;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [LANES-1:0] pick(logic [WW-1:0] w, int odd);
        logic [LANES-1:0] r;
        for (int i = 0; i < LANES; i++) r[i] = w[2*i+odd];
        return r;
    endfunction

    function automatic logic [31:0] pat(int n);
        logic [31:0] v;
        v = n * 32'h9E3779B1;
        v = v ^ (v >> 15);
        if (n % 29 == 0) v = 32'h7FFF;
        if (n % 31 == 0) v = 32'h0;
        if (n % 16 < 2)  v = 32'h1 << (n % 15);
        return v;
    endfunction

    task automatic model_reset();
        m_cap = '0; m_shown = '0;
        m_cap_ovf = 1'b0; m_shown_ovf = 1'b0;
        m_ph = 2'd0; m_edge = 0;
    endtask

    // Called just after a rising edge; leaves reset released and model cleared.
    task automatic do_reset(input int first_ph, input int seed);
        logic [31:0] v;
        rst_n = 1'b0;
        #0.5;
        for (int k = 0; k < 3; k++) begin
            // R9: outputs held low during reset
            chk("R9", "lanes in reset", 32'(lane), 32'h0);
            chk("R9", "lane_ovf in reset", 32'(lane_ovf), 32'h0);
            chk("R9", "fwd_clk in reset", 32'(fwd_clk), 32'h0);
            @(posedge clk);
            #1;
        end
        v = pat(seed);
        smp_word  = v[WW-1:0];
        smp_ovf   = v[WW];
        phase_sel = 2'(first_ph);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic run_edges(input int count, input int seg_ph, input int seed);
        int q;
        logic [1:0] d;
        logic [31:0] v;
        string req;
        for (int k = 0; k < count; k++) begin
            @(posedge clk);
            m_edge++;
            q = (m_edge - 1) % 4;
            if (q == 0) begin
                // R3 R8: only boundary edges sample the inputs
                m_shown     = m_cap;
                m_shown_ovf = m_cap_ovf;
                m_cap       = smp_word;
                m_cap_ovf   = smp_ovf;
                m_ph        = phase_sel;
            end
            #1;
            if (m_edge <= 4) req = "R10";
            else req = (q < 2) ? "R1" : "R2";
            chk(req, "lanes", 32'(lane), 32'(pick(m_shown, (q < 2) ? 0 : 1)));
            chk((q < 2) ? "R4" : "R5", "lane_ovf", 32'(lane_ovf),
                32'((q < 2) ? m_shown_ovf : 1'b0));
            d = 2'(q) - m_ph;
            chk((m_ph == 2'd0) ? "R6" : "R7", "fwd_clk", 32'(fwd_clk), 32'(d[1]));
            // Drive next inputs; non-boundary values act as decoys (R3, R8)
            v = pat(seed + k);
            smp_word  = v[WW-1:0];
            smp_ovf   = v[WW];
            phase_sel = (q == 3) ? 2'(seg_ph) : 2'((seg_ph + 1 + k) % 4);
        end
    endtask

    initial begin
        @(posedge clk);
        #1;
        do_reset(0, 7);
        run_edges(240, 0, 100);
        run_edges(240, 1, 1100);
        @(posedge clk);
        #1;
        do_reset(2, 55);
        run_edges(240, 2, 2100);
        run_edges(240, 3, 3100);
        run_edges(120, 0, 4100);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_fail++;
            $display("FAIL R3 watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule